// File: doc/BRIEF.md
# Cascadable Four-Counter Timer Block

This block contains four 16-bit up/down counters that share a single register bus. A per-counter mode field sets what makes a counter step. The choices are every clock, rising edges on a selected external input, or rising edges on that input once a second input has fired. The fourth choice is the compare event of another counter in the same block.

When counters are linked through their compare events, a chain of up to four stages acts as one synchronous counter of up to 64 bits. A linked stage takes its step direction from the stage that feeds it. Every stage of the chain updates on the same clock edge.

A read of any live count register captures all four counts into hold registers at once. Software can then read the other words of a wide value later and still get one coherent value, even while the counters keep running.

Top module: `cascade_quad_counter`

## Requirements
- R1: After reset, every control, compare, load, count and hold register of all four counters reads as zero.
- R2: Control bits [2:0] select the mode: 000 holds, 001 steps every clock, 010 steps on each rising edge of the external input chosen by control bits [7:6], 110 is the triggered mode, 111 is the linked mode. Values 011, 100 and 101 hold. Control bit [5] sets the own direction (0 up, 1 down). An input held high counts once.
- R3: When a counter steps while its value equals its compare register, it loads its load register instead of moving by one, and this produces its compare event. Otherwise it moves by one in its direction, wrapping modulo 2^16.
- R4: In linked mode (111), a counter steps exactly when the counter chosen by control bits [4:3] has a compare event. A choice equal to or above the counter's own index makes it hold.
- R5: A linked counter steps up when its source's effective direction is up and down when that direction is down. Its own direction bit has no effect.
- R6: Four counters linked 0→1→2→3, with counter 0 stepping every clock, count as one 64-bit value. Carries (up: compare FFFF, load 0) and borrows (down: compare 0, load FFFF) reach every stage on the same edge.
- R7: In triggered mode (110), no primary-input edges are counted until a rising edge is seen on the secondary input chosen by control bits [9:8]. After that, each primary rising edge counts. Leaving mode 110 disarms the counter.
- R8: A bus read of any counter's count register copies all four live counts into the hold registers on that clock edge. At all other times the hold registers keep their values.
- R9: A bus write to a count register loads the value on the next edge, overriding that counter's step, and leaves the hold registers unchanged.
- R10: Address bits [4:3] pick the counter and bits [2:0] pick the register: 0 control (10 bits stored, upper bits read zero), 1 compare, 2 load, 3 live count, 4 hold. Register selects 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a count read triggers the snapshot) |
| bus_addr | input | 5 | Counter index [4:3] and register select [2:0] |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from the address |
| ext_in | input | NUM_EXT | External count and trigger inputs, synchronous to clk |

## Verification
The 64-bit chain is run up and down from start values just below each 16-bit carry or borrow boundary, plus the full 64-bit wrap and one mid-range value. Each upper stage has its own direction bit set against the chain, so a stage that used its own direction instead of its source's would show up. The snapshot is read several cycles after capture while the chain keeps running, which separates a coherent capture from reads of live words. Single-counter runs use a reload compare inside the count range, input pulses on selected and unselected pins, held-high inputs, and pre- and post-trigger edges. Illegal source choices are tried next to a legal one that produces events, so they cannot pass by accident.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

   localparam int CTRL_W  = 10;
   localparam int MAX_CNT = 4;
   localparam int MAX_EXT = 4;
   localparam int IDX_W   = 2;
   localparam int REG_W   = 3;

   typedef enum logic [2:0] {
      MODE_STOP = 3'b000,
      MODE_CLK  = 3'b001,
      MODE_PRI  = 3'b010,
      MODE_TRIG = 3'b110,
      MODE_LINK = 3'b111
   } mode_e;

   typedef struct packed {
      logic [1:0] sec_sel;
      logic [1:0] pri_sel;
      logic       down;
      logic [1:0] src_sel;
      mode_e      mode;
   } ctrl_t;

   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_CMP  = 3'd1,
      REG_LOAD = 3'd2,
      REG_CNT  = 3'd3,
      REG_HOLD = 3'd4
   } reg_e;

endpackage

// File: rtl/qcc_edge_detect.sv
module qcc_edge_detect #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] rise
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= din;
   end

   assign rise = din & ~prev_q;

   // R2: a level held high yields one edge only
   a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      rise[0] |=> !rise[0]);

endmodule

// File: rtl/qcc_count_select.sv
module qcc_count_select
   import qcc_pkg::*;
#(
   parameter int IDX = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  ctrl_t              ctrl,
   input  logic [MAX_EXT-1:0] ext_rise,
   input  logic [MAX_CNT-1:0] src_evt,
   input  logic [MAX_CNT-1:0] src_down,
   output logic               tick,
   output logic               down
);

   logic armed_q;
   logic src_ok;

   // only lower-indexed sources keep the linked path loop-free
   assign src_ok = (int'(ctrl.src_sel) < IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        armed_q <= 1'b0;
      else if (ctrl.mode != MODE_TRIG)   armed_q <= 1'b0;
      else if (ext_rise[ctrl.sec_sel])   armed_q <= 1'b1;
   end

   always_comb begin
      tick = 1'b0;
      down = ctrl.down;
      case (ctrl.mode)
         MODE_CLK:  tick = 1'b1;
         MODE_PRI:  tick = ext_rise[ctrl.pri_sel];
         MODE_TRIG: tick = armed_q & ext_rise[ctrl.pri_sel];
         MODE_LINK: begin
            if (src_ok) begin
               tick = src_evt[ctrl.src_sel];
               down = src_down[ctrl.src_sel];
            end
         end
         default:   tick = 1'b0;
      endcase
   end

   // R7: no step in triggered mode before the trigger edge
   a_r7_wait_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.mode == MODE_TRIG && !armed_q) |-> !tick);

   // R4: a self or higher source never steps the counter
   a_r4_bad_source_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.mode == MODE_LINK && !src_ok) |-> !tick);

endmodule

// File: rtl/qcc_counter_stage.sv
module qcc_counter_stage #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             down,
   input  logic             wr_cmp,
   input  logic             wr_load,
   input  logic             wr_cnt,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] load,
   output logic             evt
);

   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] load_q;
   logic             at_cmp;

   assign at_cmp = (cnt_q == cmp_q);
   assign evt    = tick & at_cmp;
   assign cnt    = cnt_q;
   assign cmp    = cmp_q;
   assign load   = load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cmp_q  <= '0;
         load_q <= '0;
      end else begin
         if (wr_cmp)  cmp_q  <= wdata;
         if (wr_load) load_q <= wdata;
         if (wr_cnt) begin
            cnt_q <= wdata;
         end else if (tick) begin
            if (at_cmp)    cnt_q <= load_q;
            else if (down) cnt_q <= cnt_q - STEP;
            else           cnt_q <= cnt_q + STEP;
         end
      end
   end

   // R3: a step at the compare value reloads
   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_cnt && cnt_q == cmp_q) |=> (cnt_q == $past(load_q)));

   // R3: an ordinary up step adds one
   a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_cnt && !down && cnt_q != cmp_q) |=> (cnt_q == $past(cnt_q) + STEP));

   // R3: an ordinary down step subtracts one
   a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_cnt && down && cnt_q != cmp_q) |=> (cnt_q == $past(cnt_q) - STEP));

   // R9: a write lands on the next edge
   a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/qcc_snapshot.sv
module qcc_snapshot #(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            snap,
   input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
   output logic [NUM_CNT-1:0][CNT_W-1:0]   hold_all
);

   logic [NUM_CNT-1:0][CNT_W-1:0] hold_q;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    hold_q[i] <= '0;
         else if (snap) hold_q[i] <= cnt_all[i];
      end
   end

   assign hold_all = hold_q;

   // R8: one capture takes every counter of the same edge
   a_r8_capture_all: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> (hold_all == $past(cnt_all)));

   // R8: without a capture the hold registers stay put
   a_r8_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(hold_all));

endmodule

// File: rtl/cascade_quad_counter.sv
module cascade_quad_counter
   import qcc_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 16,
   parameter int NUM_EXT = 4,
   localparam int ADDR_W = IDX_W + REG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [CNT_W-1:0]   bus_wdata,
   output logic [CNT_W-1:0]   bus_rdata,
   input  logic [NUM_EXT-1:0] ext_in
);

   // elaboration-time parameter checks
   if (NUM_CNT < 2 || NUM_CNT > MAX_CNT) begin : g_bad_num_cnt
      $error("cascade_quad_counter: NUM_CNT must be 2..4");
   end
   if (NUM_EXT < 1 || NUM_EXT > MAX_EXT) begin : g_bad_num_ext
      $error("cascade_quad_counter: NUM_EXT must be 1..4");
   end
   if (CNT_W < CTRL_W) begin : g_bad_cnt_w
      $error("cascade_quad_counter: CNT_W must hold the control field");
   end

   // address decode
   logic [IDX_W-1:0] sel_idx;
   reg_e             sel_reg;
   logic             idx_ok;
   logic             snap;

   assign sel_idx = bus_addr[ADDR_W-1:REG_W];
   assign sel_reg = reg_e'(bus_addr[REG_W-1:0]);
   assign idx_ok  = (int'(sel_idx) < NUM_CNT);
   assign snap    = bus_rd & idx_ok & (sel_reg == REG_CNT);

   // external input edges, widened to the fixed select range
   logic [NUM_EXT-1:0] ext_rise;
   logic [MAX_EXT-1:0] ext_rise_pad;

   qcc_edge_detect #(.WIDTH(NUM_EXT)) u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ext_in),
      .rise  (ext_rise)
   );

   assign ext_rise_pad = MAX_EXT'(ext_rise);

   // per-counter state
   ctrl_t [NUM_CNT-1:0]            ctrl_all;
   logic  [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
   logic  [NUM_CNT-1:0][CNT_W-1:0] cmp_all;
   logic  [NUM_CNT-1:0][CNT_W-1:0] load_all;
   logic  [NUM_CNT-1:0][CNT_W-1:0] hold_all;
   logic  [MAX_CNT-1:0]            evt_pad;
   logic  [MAX_CNT-1:0]            dir_pad;

   for (genvar i = 0; i < MAX_CNT; i++) begin : g_stage
      if (i < NUM_CNT) begin : g_live
         ctrl_t ctrl_q;
         logic  hit;
         logic  tick;
         logic  eff_down;
         logic  evt;

         assign hit = bus_wr & (sel_idx == IDX_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ctrl_q <= '0;
            else if (hit && sel_reg == REG_CTRL)
               ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         end

         qcc_count_select #(.IDX(i)) u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl     (ctrl_q),
            .ext_rise (ext_rise_pad),
            .src_evt  (evt_pad),
            .src_down (dir_pad),
            .tick     (tick),
            .down     (eff_down)
         );

         qcc_counter_stage #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .down    (eff_down),
            .wr_cmp  (hit && sel_reg == REG_CMP),
            .wr_load (hit && sel_reg == REG_LOAD),
            .wr_cnt  (hit && sel_reg == REG_CNT),
            .wdata   (bus_wdata),
            .cnt     (cnt_all[i]),
            .cmp     (cmp_all[i]),
            .load    (load_all[i]),
            .evt     (evt)
         );

         assign ctrl_all[i] = ctrl_q;
         assign evt_pad[i]  = evt;
         assign dir_pad[i]  = eff_down;
      end else begin : g_absent
         assign evt_pad[i] = 1'b0;
         assign dir_pad[i] = 1'b0;
      end
   end

   qcc_snapshot #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .snap     (snap),
      .cnt_all  (cnt_all),
      .hold_all (hold_all)
   );

   // read path
   always_comb begin
      bus_rdata = '0;
      if (idx_ok) begin
         case (sel_reg)
            REG_CTRL: bus_rdata = CNT_W'(ctrl_all[sel_idx]);
            REG_CMP:  bus_rdata = cmp_all[sel_idx];
            REG_LOAD: bus_rdata = load_all[sel_idx];
            REG_CNT:  bus_rdata = cnt_all[sel_idx];
            REG_HOLD: bus_rdata = hold_all[sel_idx];
            default:  bus_rdata = '0;
         endcase
      end
   end

   // R10: unmapped register selects read zero
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_addr[REG_W-1:0]) > 4) |-> (bus_rdata == '0));

endmodule

// File: tb/cascade_quad_counter_tb.sv
`timescale 1ns/1ps
module cascade_quad_counter_tb_top;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [CW-1:0] bus_wdata = '0;
   logic [CW-1:0] bus_rdata;
   logic [3:0]    ext_in = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cascade_quad_counter dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ext_in    (ext_in)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all bus tasks start and end at a falling edge
   task automatic wr(input int idx, input int rg, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = {idx[1:0], rg[2:0]}; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int idx, input int rg, output logic [15:0] d);
      bus_rd = 1'b1; bus_addr = {idx[1:0], rg[2:0]};
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int b);
      ext_in[b] = 1'b1;
      @(negedge clk);
      ext_in[b] = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [15:0] ctl(input logic [2:0] m, input logic [1:0] s,
                                       input logic dn, input logic [1:0] p, input logic [1:0] sc);
      return {6'b0, sc, p, dn, s, m};
   endfunction

   function automatic logic [15:0] model(input logic [15:0] v, input logic [15:0] cv,
                                         input logic [15:0] lv, input logic dn, input int n);
      for (int s = 0; s < n; s++) v = (v == cv) ? lv : (dn ? v - 16'd1 : v + 16'd1);
      return v;
   endfunction

   // four-stage chain; upper stages carry the opposite own direction bit
   task automatic chain(input logic dn, input logic [63:0] start, input int k, input string tag);
      logic [63:0] exp;
      logic [63:0] got;
      logic [15:0] d;
      wr(0, 0, ctl(3'b000, 2'd0, dn, 2'd0, 2'd0));
      for (int i = 0; i < 4; i++) begin
         if (i > 0) wr(i, 0, ctl(3'b111, 2'(i - 1), ~dn, 2'd0, 2'd0));
         wr(i, 1, dn ? 16'h0000 : 16'hFFFF);
         wr(i, 2, dn ? 16'hFFFF : 16'h0000);
      end
      for (int i = 0; i < 4; i++) wr(i, 3, start[16*i +: 16]);
      wr(0, 0, ctl(3'b001, 2'd0, dn, 2'd0, 2'd0));
      idle(k);
      exp = dn ? start - 64'(k) : start + 64'(k);
      rd(0, 3, d);
      chk({tag, " R6 live low word"}, {48'd0, d}, {48'd0, exp[15:0]});
      idle(3);
      for (int i = 0; i < 4; i++) begin
         rd(i, 4, d);
         got[16*i +: 16] = d;
      end
      chk({tag, " R6 R5 R8 coherent 64-bit snapshot"}, got, exp);
   endtask

   initial begin : main
      logic [15:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: everything zero after reset
      for (int i = 0; i < 4; i++)
         for (int r = 0; r < 5; r++) begin
            rd(i, r, d);
            chk($sformatf("R1 reset counter %0d reg %0d", i, r), {48'd0, d}, 64'd0);
         end

      // R6 R5 R8: up chain across each carry boundary and the full wrap
      chain(1'b0, 64'h0000_0000_0000_FFFC, 5, "up c0->c1");
      chain(1'b0, 64'h0000_0000_FFFF_FFFD, 5, "up c1->c2");
      chain(1'b0, 64'h0000_FFFF_FFFF_FFFE, 5, "up c2->c3");
      chain(1'b0, 64'hFFFF_FFFF_FFFF_FFFB, 7, "up 64-bit wrap");
      chain(1'b0, 64'h1234_5678_9ABC_DEF0, 9, "up mid-range");
      // R6 R5 R8: down chain across each borrow boundary and the full wrap
      chain(1'b1, 64'h0000_0000_0001_0002, 5, "down c1->c0");
      chain(1'b1, 64'h0000_0001_0000_0003, 5, "down c2->c1");
      chain(1'b1, 64'h0001_0000_0000_0001, 5, "down c3->c2");
      chain(1'b1, 64'h0000_0000_0000_0002, 5, "down 64-bit wrap");
      chain(1'b1, 64'h8000_0000_0000_0000, 6, "down mid-range");

      // R3: reload inside the range, up then down
      wr(0, 0, ctl(3'b000, 2'd0, 1'b0, 2'd0, 2'd0));
      wr(0, 1, 16'd5); wr(0, 2, 16'd2); wr(0, 3, 16'd0);
      wr(0, 0, ctl(3'b001, 2'd0, 1'b0, 2'd0, 2'd0));
      idle(8);
      rd(0, 3, d);
      chk("R3 up reload at compare", {48'd0, d}, {48'd0, model(16'd0, 16'd5, 16'd2, 1'b0, 8)});
      wr(0, 0, ctl(3'b000, 2'd0, 1'b1, 2'd0, 2'd0));
      wr(0, 1, 16'd3); wr(0, 2, 16'd9); wr(0, 3, 16'd12);
      wr(0, 0, ctl(3'b001, 2'd0, 1'b1, 2'd0, 2'd0));
      idle(15);
      rd(0, 3, d);
      chk("R3 down reload at compare", {48'd0, d}, {48'd0, model(16'd12, 16'd3, 16'd9, 1'b1, 15)});

      // R2: primary-input mode, selected pin 2
      wr(0, 0, ctl(3'b000, 2'd0, 1'b0, 2'd0, 2'd0));
      wr(0, 1, 16'hFFFF); wr(0, 3, 16'd100);
      wr(0, 0, ctl(3'b010, 2'd0, 1'b0, 2'd2, 2'd0));
      for (int p = 0; p < 4; p++) pulse(2);
      pulse(1); pulse(3);
      ext_in[2] = 1'b1; idle(5); ext_in[2] = 1'b0; idle(1);
      rd(0, 3, d);
      chk("R2 primary edges counted, other pins ignored", {48'd0, d}, 64'd105);
      // R2: unused mode value holds
      wr(0, 0, ctl(3'b011, 2'd0, 1'b0, 2'd2, 2'd0));
      idle(6);
      rd(0, 3, d);
      chk("R2 mode 011 holds", {48'd0, d}, 64'd105);

      // R7: triggered mode, primary pin 0, secondary pin 1
      wr(0, 0, ctl(3'b000, 2'd0, 1'b0, 2'd0, 2'd0));
      wr(0, 3, 16'd0);
      wr(0, 0, ctl(3'b110, 2'd0, 1'b0, 2'd0, 2'd1));
      for (int p = 0; p < 3; p++) pulse(0);
      rd(0, 3, d);
      chk("R7 no count before trigger", {48'd0, d}, 64'd0);
      pulse(1);
      pulse(0); pulse(0);
      rd(0, 3, d);
      chk("R7 counts after trigger", {48'd0, d}, 64'd2);
      wr(0, 0, ctl(3'b000, 2'd0, 1'b0, 2'd0, 2'd1));
      wr(0, 0, ctl(3'b110, 2'd0, 1'b0, 2'd0, 2'd1));
      pulse(0);
      rd(0, 3, d);
      chk("R7 leaving the mode disarms", {48'd0, d}, 64'd2);

      // R4: self and higher sources hold, a lower source counts
      wr(0, 0, ctl(3'b000, 2'd0, 1'b0, 2'd0, 2'd0));
      wr(0, 1, 16'd1); wr(0, 2, 16'd0); wr(0, 3, 16'd0);
      wr(1, 0, ctl(3'b111, 2'd1, 1'b0, 2'd0, 2'd0)); wr(1, 3, 16'h1234);
      wr(2, 0, ctl(3'b111, 2'd3, 1'b0, 2'd0, 2'd0)); wr(2, 3, 16'h4321);
      wr(3, 0, ctl(3'b111, 2'd0, 1'b0, 2'd0, 2'd0));
      wr(3, 1, 16'd2); wr(3, 2, 16'd0); wr(3, 3, 16'd0);
      wr(0, 0, ctl(3'b001, 2'd0, 1'b0, 2'd0, 2'd0));
      idle(10);
      rd(0, 3, d);
      chk("R8 snapshot read returns live value", {48'd0, d}, {48'd0, model(16'd0, 16'd1, 16'd0, 1'b0, 10)});
      rd(1, 4, d);
      chk("R4 self source holds", {48'd0, d}, 64'h1234);
      rd(2, 4, d);
      chk("R4 higher source holds", {48'd0, d}, 64'h4321);
      rd(3, 4, d);
      chk("R4 lower source steps on its events", {48'd0, d}, {48'd0, model(16'd0, 16'd2, 16'd0, 1'b0, 5)});

      // R9: count write leaves hold untouched
      wr(2, 3, 16'hABCD);
      rd(2, 4, d);
      chk("R9 hold unchanged by count write", {48'd0, d}, 64'h4321);
      rd(2, 3, d);
      chk("R9 count write landed", {48'd0, d}, 64'hABCD);

      // R10: control width, register readback, unmapped selects
      wr(0, 0, ctl(3'b000, 2'd0, 1'b0, 2'd0, 2'd0));
      wr(3, 0, 16'hFFFF);
      rd(3, 0, d);
      chk("R10 control keeps 10 bits", {48'd0, d}, 64'h03FF);
      rd(3, 1, d);
      chk("R10 compare readback", {48'd0, d}, 64'd2);
      rd(1, 5, d);
      chk("R10 select 5 reads zero", {48'd0, d}, 64'd0);
      rd(1, 7, d);
      chk("R10 select 7 reads zero", {48'd0, d}, 64'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      #500000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule